// File: doc/BRIEF.md
# Multi-slot I2S serial audio transmitter

This block turns parallel 32-bit audio words into a serial data stream in I2S framing. A frame has two halves. The half where the frame sync is low carries a programmable number of left slots. The half where it is high carries a programmable number of right slots. Each slot is one 32-bit word, sent MSB first. Once the active slots of a half have been sent, the block sends zeros until that half ends. The first data bit of each half comes one bit clock after the frame-sync transition.

Everything runs on one fast system clock. In target mode, the bit clock and the frame sync come from outside the block. They are resynchronised into the system clock, and their edges are detected there. In controller mode, a one-cycle `bit_tick` strobe stands in for each bit clock. The block builds the frame sync itself, with each phase lasting half of `frame_len` ticks. Both modes raise an error flag for a broken configuration. In target mode the flag is raised when a frame-sync edge arrives before the current half has finished its slots. In controller mode it is raised when a half-frame is too short for its slot count.

The word source feeds the block through a valid/ready exchange, but it cannot apply back-pressure, because the serial line never stalls. At each half-frame load point the block samples the word bus for that side and pulses `words_ready`. If `words_valid` is low at that moment, the half is sent as all zeros. The words may change at any other time. `ctrl_mode` is static and may be changed only while the block is in reset. In controller mode, `bit_tick` must not be high on two consecutive system clocks.

Top module: `i2s_slot_tx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after release, `sdout`, `words_ready`, `sync_err` and `cfg_err` are 0 and `fsync_out` is 1.
- R2: A half-frame starts at the bit-clock rise where the sampled frame sync differs from its value at the previous rise. The value before the first rise counts as 1. From the second bit-clock fall after the start, `sdout` carries one bit per fall, MSB first. It sends slot 0 first, and slot i is taken from bits [32i+31:32i] of the word bus. A low half sends `left_words` and a high half sends `right_words`.
- R3: After the active slots of a half, `sdout` is 0 for the rest of that half. A slot count of 0 gives an all-zero half. A count above MAX_SLOTS (default 4) acts as MAX_SLOTS.
- R4: The first bit-clock fall of a half carries the next bit of the previous half's stream. That bit is the LSB of the last active slot when the previous half lasted exactly (active slots × 32) bit clocks, and 0 when it lasted longer.
- R5: In controller mode, `fsync_out` changes only in the clock after a `bit_tick`. It toggles once every floor(`frame_len`/2) ticks. It is 1 after reset, so the first tick drives it low. In target mode, `fsync_out` stays 1.
- R6: In controller mode, `cfg_err` is 1 while floor(`frame_len`/2) is less than 32 × (clamped left count) or less than 32 × (clamped right count). While it is 1, `sdout` is 0. In target mode, `cfg_err` is 0.
- R7: In target mode, `sync_err` becomes 1 when a half-frame start arrives after a load and before the stream of that load has fully gone out. It then stays 1 until reset. A half of at least (active slots × 32) bit clocks never sets it.
- R8: At each load point (the second bit-clock fall of a half) `words_ready` pulses for one clock. The half's words are captured at that moment, and later changes to the bus do not affect it. If `words_valid` is low at the load point, the whole half is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_mode | input | 1 | 1 = block generates frame sync from `bit_tick`, 0 = follows external clocks |
| bclk_in | input | 1 | External bit clock (target mode) |
| fsync_in | input | 1 | External frame sync (target mode) |
| bit_tick | input | 1 | One-clock strobe per bit clock (controller mode) |
| frame_len | input | FLEN_W | Frame length in bit clocks (controller mode) |
| left_cnt | input | CNT_W | Active left slots |
| right_cnt | input | CNT_W | Active right slots |
| left_words | input | MAX_SLOTS*32 | Left slot words, slot 0 in the low bits |
| right_words | input | MAX_SLOTS*32 | Right slot words, slot 0 in the low bits |
| words_valid | input | 1 | Word buses hold valid samples |
| words_ready | output | 1 | Capture strobe at each half-frame load |
| sdout | output | 1 | Serial data |
| fsync_out | output | 1 | Generated frame sync |
| sync_err | output | 1 | Sticky flag: target-mode half-frame too short |
| cfg_err | output | 1 | Controller-mode slot counts do not fit the frame |

## Verification
Some rules are checked by the assertions on every clock:
- `sdout` moves only on a bit-clock fall event, or when it is forced to zero.
- `fsync_out` moves only after a tick.
- `words_ready` is always a single-clock pulse that follows a fall.
- The sync error never clears.
- A configuration error silences the data line.

The following need the bench's reference model and its scenarios:
- where the one-bit delay and the half-frame start land;
- the slot order and bit order;
- the zero fill and the clamping of slot counts;
- the carry of a last LSB into the next half;
- the capture of words at load time, with changes made mid-half, and the all-zero half when no words are valid;
- the exact phase lengths of the generated frame sync.

// File: rtl/i2s_slot_tx_pkg.sv
package i2s_slot_tx_pkg;
  localparam int WORD_W = 32;

  // half-frame progress: SKIP = one-bit delay fall pending, LOAD = next fall loads
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_LOAD = 2'd1,
    PH_SKIP = 2'd2
  } phase_t;
endpackage

// File: rtl/i2s_slot_tx_sync.sv
module i2s_slot_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fsync_in,
  output logic rise_ev,
  output logic fall_ev,
  output logic fs_lvl
);
  logic [STAGES-1:0] b_sh;
  logic [STAGES-1:0] f_sh;
  logic              b_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sh   <= '0;
      f_sh   <= '1;
      b_prev <= 1'b0;
    end else begin
      b_sh   <= {b_sh[STAGES-2:0], bclk_in};
      f_sh   <= {f_sh[STAGES-2:0], fsync_in};
      b_prev <= b_sh[STAGES-1];
    end
  end

  // frame sync travels through the same depth as the bit clock
  assign rise_ev = b_sh[STAGES-1] & ~b_prev;
  assign fall_ev = ~b_sh[STAGES-1] & b_prev;
  assign fs_lvl  = f_sh[STAGES-1];
endmodule

// File: rtl/i2s_slot_tx_fsgen.sv
module i2s_slot_tx_fsgen #(
  parameter int FLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_tick,
  input  logic [FLEN_W-1:0] frame_len,
  output logic              fs,
  output logic              rise_ev,
  output logic              fall_ev
);
  logic [FLEN_W-1:0] hc;
  logic [FLEN_W-1:0] half;
  logic [FLEN_W:0]   hc_inc;
  logic              reach;
  logic              fs_q;
  logic              t1;
  logic              t2;

  assign half   = frame_len >> 1;
  assign hc_inc = {1'b0, hc} + {{FLEN_W{1'b0}}, 1'b1};
  assign reach  = hc_inc >= {1'b0, half};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc   <= '1;
      fs_q <= 1'b1;
      t1   <= 1'b0;
      t2   <= 1'b0;
    end else begin
      if (en && bit_tick) begin
        if (reach) begin
          hc   <= '0;
          fs_q <= ~fs_q;
        end else begin
          hc <= hc_inc[FLEN_W-1:0];
        end
      end
      t1 <= en & bit_tick;
      t2 <= t1;
    end
  end

  // rise is seen one clock after the tick so the new sync level is visible
  assign fs      = fs_q;
  assign rise_ev = t1;
  assign fall_ev = t2;
endmodule

// File: rtl/i2s_slot_tx_ser.sv
module i2s_slot_tx_ser
  import i2s_slot_tx_pkg::*;
#(
  parameter  int MAX_SLOTS = 4,
  localparam int CNT_W     = $clog2(MAX_SLOTS + 1),
  localparam int SR_W      = MAX_SLOTS * WORD_W,
  localparam int NW        = $clog2(SR_W + 2) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             fs_lvl,
  input  logic             chk_en,
  input  logic             zero_out,
  input  logic             words_valid,
  input  logic [SR_W-1:0]  left_words,
  input  logic [SR_W-1:0]  right_words,
  input  logic [CNT_W-1:0] left_cnt,
  input  logic [CNT_W-1:0] right_cnt,
  output logic             sdout,
  output logic             words_ready,
  output logic             sync_err
);
  localparam logic [NW-1:0] SENT_MAX = NW'(SR_W);

  phase_t           ph;
  logic             fs_last;
  logic             side;
  logic             loaded;
  logic             sd_q;
  logic             rdy_q;
  logic             err_q;
  logic [SR_W-1:0]  sr;
  logic [SR_W-1:0]  stream;
  logic [SR_W-1:0]  words_sel;
  logic [CNT_W-1:0] cnt_sel;
  logic [NW-1:0]    sent;
  logic [NW-1:0]    need;
  logic [NW-1:0]    need_new;
  logic             start;

  assign cnt_sel   = side ? right_cnt : left_cnt;
  assign words_sel = side ? right_words : left_words;
  assign need_new  = NW'(cnt_sel) * NW'(WORD_W);
  assign start     = rise_ev && (fs_lvl != fs_last);

  // pack the active slots MSB-first, slot 0 leading; the rest stays zero
  always_comb begin
    stream = '0;
    if (words_valid) begin
      for (int i = 0; i < MAX_SLOTS; i++) begin
        if (CNT_W'(i) < cnt_sel)
          stream[SR_W-1-i*WORD_W -: WORD_W] = words_sel[i*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_RUN;
      fs_last <= 1'b1;
      side    <= 1'b0;
      loaded  <= 1'b0;
      sd_q    <= 1'b0;
      rdy_q   <= 1'b0;
      err_q   <= 1'b0;
      sr      <= '0;
      sent    <= '0;
      need    <= '0;
    end else begin
      rdy_q <= 1'b0;
      if (start) begin
        fs_last <= fs_lvl;
        side    <= fs_lvl;
        ph      <= PH_SKIP;
        // the delay fall still belongs to the old half, hence the +1
        if (chk_en && loaded && ((sent + NW'(1)) < need))
          err_q <= 1'b1;
      end
      if (fall_ev) begin
        if (ph == PH_LOAD) begin
          sr     <= stream << 1;
          sd_q   <= stream[SR_W-1];
          need   <= need_new;
          sent   <= NW'(1);
          loaded <= 1'b1;
          rdy_q  <= 1'b1;
          ph     <= PH_RUN;
        end else begin
          sd_q <= sr[SR_W-1];
          sr   <= sr << 1;
          if (sent != SENT_MAX)
            sent <= sent + NW'(1);
          if (ph == PH_SKIP)
            ph <= PH_LOAD;
        end
      end
      if (zero_out)
        sd_q <= 1'b0;
    end
  end

  assign sdout       = sd_q;
  assign words_ready = rdy_q;
  assign sync_err    = err_q;
endmodule

// File: rtl/i2s_slot_tx.sv
module i2s_slot_tx
  import i2s_slot_tx_pkg::*;
#(
  parameter  int MAX_SLOTS   = 4,
  parameter  int FLEN_W      = 12,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(MAX_SLOTS + 1),
  localparam int SR_W        = MAX_SLOTS * WORD_W,
  localparam int CMPW        = FLEN_W + CNT_W + $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_mode,
  input  logic              bclk_in,
  input  logic              fsync_in,
  input  logic              bit_tick,
  input  logic [FLEN_W-1:0] frame_len,
  input  logic [CNT_W-1:0]  left_cnt,
  input  logic [CNT_W-1:0]  right_cnt,
  input  logic [SR_W-1:0]   left_words,
  input  logic [SR_W-1:0]   right_words,
  input  logic              words_valid,
  output logic              words_ready,
  output logic              sdout,
  output logic              fsync_out,
  output logic              sync_err,
  output logic              cfg_err
);
  logic             t_rise, t_fall, t_fs;
  logic             g_rise, g_fall, g_fs;
  logic             rise_ev, fall_ev, fs_lvl;
  logic [CNT_W-1:0] lc, rc;
  logic [FLEN_W-1:0] half_len;
  logic             cfg_next;
  logic             cfg_q;

  i2s_slot_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_in  (bclk_in),
    .fsync_in (fsync_in),
    .rise_ev  (t_rise),
    .fall_ev  (t_fall),
    .fs_lvl   (t_fs)
  );

  i2s_slot_tx_fsgen #(.FLEN_W(FLEN_W)) u_fsgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_mode),
    .bit_tick  (bit_tick),
    .frame_len (frame_len),
    .fs        (g_fs),
    .rise_ev   (g_rise),
    .fall_ev   (g_fall)
  );

  assign rise_ev = ctrl_mode ? g_rise : t_rise;
  assign fall_ev = ctrl_mode ? g_fall : t_fall;
  assign fs_lvl  = ctrl_mode ? g_fs   : t_fs;

  assign lc = (left_cnt  > CNT_W'(MAX_SLOTS)) ? CNT_W'(MAX_SLOTS) : left_cnt;
  assign rc = (right_cnt > CNT_W'(MAX_SLOTS)) ? CNT_W'(MAX_SLOTS) : right_cnt;

  assign half_len = frame_len >> 1;
  assign cfg_next = ctrl_mode &&
                    ((CMPW'(half_len) < CMPW'(lc) * CMPW'(WORD_W)) ||
                     (CMPW'(half_len) < CMPW'(rc) * CMPW'(WORD_W)));

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= 1'b0;
    else        cfg_q <= cfg_next;
  end

  i2s_slot_tx_ser #(.MAX_SLOTS(MAX_SLOTS)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_ev     (rise_ev),
    .fall_ev     (fall_ev),
    .fs_lvl      (fs_lvl),
    .chk_en      (~ctrl_mode),
    .zero_out    (ctrl_mode & cfg_q),
    .words_valid (words_valid),
    .left_words  (left_words),
    .right_words (right_words),
    .left_cnt    (lc),
    .right_cnt   (rc),
    .sdout       (sdout),
    .words_ready (words_ready),
    .sync_err    (sync_err)
  );

  assign fsync_out = g_fs;
  assign cfg_err   = cfg_q;
endmodule

// File: rtl/i2s_slot_tx_chk.sv
module i2s_slot_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_mode,
  input logic bit_tick,
  input logic fall_ev,
  input logic cfg_err,
  input logic sync_err,
  input logic sdout,
  input logic fsync_out,
  input logic words_ready
);
  p_sd_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_ev && !(ctrl_mode && cfg_err)) |=> $stable(sdout));

  p_fsync_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_mode && bit_tick) |=> $stable(fsync_out));

  p_cfg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_mode && cfg_err) |=> !sdout);

  p_cfg_ctrl_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(ctrl_mode));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);

  p_ready_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    words_ready |-> $past(fall_ev));

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    words_ready |=> !words_ready);
endmodule

bind i2s_slot_tx i2s_slot_tx_chk u_chk (.*);

// File: tb/i2s_slot_tx_tb.sv
`timescale 1ns/1ps
module i2s_slot_tx_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctrl_mode = 1'b0;
  logic         bclk_in = 1'b0;
  logic         fsync_in = 1'b0;
  logic         bit_tick = 1'b0;
  logic [11:0]  frame_len = 12'd128;
  logic [2:0]   left_cnt = 3'd2;
  logic [2:0]   right_cnt = 3'd2;
  logic [127:0] left_words = '0;
  logic [127:0] right_words = '0;
  logic         words_valid = 1'b1;
  logic         words_ready, sdout, fsync_out, sync_err, cfg_err;

  always #2.5 clk = ~clk;

  i2s_slot_tx u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_mode(ctrl_mode), .bclk_in(bclk_in),
    .fsync_in(fsync_in), .bit_tick(bit_tick), .frame_len(frame_len),
    .left_cnt(left_cnt), .right_cnt(right_cnt), .left_words(left_words),
    .right_words(right_words), .words_valid(words_valid),
    .words_ready(words_ready), .sdout(sdout), .fsync_out(fsync_out),
    .sync_err(sync_err), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_fail = 0, rdy_cnt = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) rdy_cnt <= 0;
    else if (words_ready) rdy_cnt <= rdy_cnt + 1;
  end

  // reference model state
  bit q[$];
  bit m_last, m_side, m_loaded, m_err, m_fs, m_cfg;
  int m_dly, m_sent, m_need, m_ready, m_hc, m_half;

  function automatic int clampc(input int c);
    return (c > 4) ? 4 : c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_last = 1'b1; m_side = 1'b0; m_loaded = 1'b0; m_err = 1'b0; m_fs = 1'b1;
    m_dly = 0; m_sent = 0; m_need = 0; m_ready = 0; m_hc = 4095;
    q.delete();
    m_half = int'(frame_len) / 2;
    m_cfg = ctrl_mode && ((m_half < clampc(int'(left_cnt)) * 32) ||
                          (m_half < clampc(int'(right_cnt)) * 32));
  endtask

  task automatic m_rise(input bit fs, input bit tgt);
    if (fs != m_last) begin
      m_last = fs; m_side = fs; m_dly = 2;
      if (tgt && m_loaded && (m_sent + 1 < m_need)) m_err = 1'b1;
    end
  endtask

  task automatic m_fall(output bit b);
    int cnt;
    if (m_dly == 1) begin
      q.delete();
      cnt = clampc(int'(m_side ? right_cnt : left_cnt));
      if (words_valid)
        for (int i = 0; i < cnt; i++)
          for (int k = 31; k >= 0; k--)
            q.push_back(m_side ? right_words[i*32+k] : left_words[i*32+k]);
      m_need = cnt * 32; m_sent = 1; m_loaded = 1'b1; m_ready++; m_dly = 0;
    end else begin
      if (m_sent < 128) m_sent++;
      if (m_dly == 2) m_dly = 1;
    end
    b = (q.size() > 0) ? q.pop_front() : 1'b0;
  endtask

  task automatic do_reset(input bit ctrl);
    @(negedge clk);
    rst_n = 1'b0; ctrl_mode = ctrl; bclk_in = 1'b0; fsync_in = 1'b0; bit_tick = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 sdout", 32'(sdout), 0);
    chk("R1 fsync_out", 32'(fsync_out), 1);
    chk("R1 words_ready", 32'(words_ready), 0);
    chk("R1 sync_err", 32'(sync_err), 0);
    chk("R1 cfg_err", 32'(cfg_err), 0);
    rst_n = 1'b1;
    m_reset();
    @(negedge clk);
    chk("R1 sdout after release", 32'(sdout), 0);
    repeat (2) @(negedge clk);
  endtask

  // one bit clock = 16 system clocks; fsync changes on the falling edge
  task automatic tgt_run(input int nf, input int lo, input int hi, input bit flip, input string tag);
    int per;
    bit cur, nxt, e;
    per = lo + hi;
    for (int f = 0; f < nf; f++) begin
      for (int b = 0; b < per; b++) begin
        cur = (b < lo) ? 1'b0 : 1'b1;
        nxt = (((b + 1) % per) < lo) ? 1'b0 : 1'b1;
        @(negedge clk);
        m_rise(cur, 1'b1);
        bclk_in = 1'b1;
        if (flip && b == lo / 2) begin
          left_words  = ~left_words;
          right_words = {right_words[0], right_words[127:1]};
        end
        repeat (8) @(negedge clk);
        m_fall(e);
        bclk_in = 1'b0; fsync_in = nxt;
        repeat (7) @(negedge clk);
        chk(tag, 32'(sdout), 32'(e));
        chk("R7 sync_err", 32'(sync_err), 32'(m_err));
        chk("R5 target fsync_out", 32'(fsync_out), 1);
      end
    end
  endtask

  task automatic ctl_run(input int nticks, input string tag);
    bit e;
    for (int k = 0; k < nticks; k++) begin
      if (m_hc + 1 >= m_half) begin m_hc = 0; m_fs = ~m_fs; end
      else m_hc++;
      m_rise(m_fs, 1'b0);
      m_fall(e);
      if (m_cfg) e = 1'b0;
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(tag, 32'(sdout), 32'(e));
      chk("R5 fsync_out", 32'(fsync_out), 32'(m_fs));
      chk("R6 cfg_err", 32'(cfg_err), 32'(m_cfg));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    left_words  = 128'h89ABCDEF_13579BDF_2468ACE1_F0E1D2C3;
    right_words = 128'h5A5A5A5B_0F0F0F0F_C3C3C3C3_76543211;

    // exact halves: framing, LSB carry into next half, mid-half word changes
    left_cnt = 3'd2; right_cnt = 3'd2; words_valid = 1'b1;
    do_reset(1'b0);
    tgt_run(3, 64, 64, 1'b1, "R2/R4 exact halves");
    chk("R8 ready count", 32'(rdy_cnt), 32'(m_ready));

    // longer halves with zero fill
    left_cnt = 3'd1; right_cnt = 3'd3;
    do_reset(1'b0);
    tgt_run(2, 40, 100, 1'b0, "R3 zero fill");

    // empty left side, right count clamped to four slots
    left_cnt = 3'd0; right_cnt = 3'd7;
    do_reset(1'b0);
    tgt_run(2, 36, 130, 1'b0, "R3 clamp and empty");

    // no valid words at the load points
    left_cnt = 3'd2; right_cnt = 3'd2; words_valid = 1'b0;
    do_reset(1'b0);
    tgt_run(1, 64, 64, 1'b0, "R8 underrun zeros");
    chk("R8 ready count underrun", 32'(rdy_cnt), 32'(m_ready));
    words_valid = 1'b1;

    // left half too short for two slots
    do_reset(1'b0);
    tgt_run(2, 50, 64, 1'b0, "R7 short half data");
    chk("R7 sticky sync_err", 32'(sync_err), 1);

    // controller mode, fitting frame
    frame_len = 12'd128; left_cnt = 3'd2; right_cnt = 3'd2;
    do_reset(1'b1);
    ctl_run(400, "R2 controller data");
    chk("R8 ready count controller", 32'(rdy_cnt), 32'(m_ready));
    chk("R7 no sync_err in controller", 32'(sync_err), 0);

    // controller mode, odd frame too short for the left slots
    frame_len = 12'd101; left_cnt = 3'd2; right_cnt = 3'd1;
    do_reset(1'b1);
    ctl_run(220, "R6 quiet sdout");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule